// File: doc/BRIEF.md
# Duty-Cycled Receive Monitor Controller

This block is a low-power watchdog for a receive path. Once it is armed, it repeats a loop without any help from software. First it spends a programmed number of cycles asleep with the receiver off. It then turns the receiver on, lets it settle for a programmed number of cycles, and sums the instantaneous power I*I + Q*Q over a window of valid baseband samples. At the end of the window it compares the sum with a programmed threshold.

If the sum is strictly larger than the threshold, the loop stops. The block raises its interrupt and requests that the whole receiver be powered up, and it holds that condition until software acknowledges it. If the sum is not larger, the block goes back to sleep and repeats the loop.

The LO channel index can stay on one entry, or it can step through a short table so that each detect interval listens on the next channel. All settings are loaded while the block is idle. Once monitoring is armed, the settings are frozen.

Top module: `rx_watch_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), and rx_en, irq, full_rx_req and power_o are all 0.
- R2: A rising edge of mon_en while idle enters sleep (state_o = 1) with rx_en low. Sleep lasts exactly sleep_len cycles, where a programmed 0 counts as 1, and is followed by settle (state_o = 2).
- R3: During settle, rx_en is high for exactly settle_len cycles, where 0 counts as 1. Samples presented during settle are not added to the measurement.
- R4: In measure (state_o = 3), the block sums I*I + Q*Q over the next win_len samples that have smp_valid high, where 0 counts as 1. Cycles with smp_valid low add nothing. The sum appears on power_o in the cycle after the last sample, when state_o = 4 (evaluate).
- R5: If the measured sum is strictly greater than the threshold, the block enters found (state_o = 5). In found, irq, full_rx_req and rx_en are all high.
- R6: If the measured sum is equal to or below the threshold, the block goes from evaluate back to sleep and continues the loop.
- R7: A configuration write is accepted only while the block is idle and mon_en is low. Writes in any other condition leave every setting unchanged. The register map, selected by cfg_addr, is: 0 = sleep_len, 1 = settle_len, 2 = win_len, 3 = threshold (32 bits), 4 = hop control (bit 0 enables hopping, bits 7:4 hold the table length), 5 = table entry (bits 5:0 hold the LO value, bits 18:16 select the slot).
- R8: With hopping enabled, lo_idx presents the table entry at a pointer. The pointer starts at 0 when monitoring is armed, advances by one on every return to sleep, and wraps to 0 after entry length-1. A length of 0 counts as 1, and a length above 8 counts as 8. With hopping disabled, lo_idx presents entry 0.
- R9: The block stays in found until irq_clr is pulsed, and then it goes to idle. Leaving idle again requires a new rising edge of mon_en.
- R10: If mon_en is low, the block is in idle one cycle later, whatever state it was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| mon_en | input | 1 | Arms monitoring on its rising edge; low forces idle |
| irq_clr | input | 1 | Acknowledges a detection and returns the block to idle |
| smp_valid | input | 1 | Sample strobe |
| smp_i | input | 12 | In-phase sample, signed |
| smp_q | input | 12 | Quadrature sample, signed |
| rx_en | output | 1 | Receiver path enable |
| full_rx_req | output | 1 | Request to power up the full receiver |
| irq | output | 1 | Detection interrupt |
| lo_idx | output | 6 | LO channel index for the current detect |
| state_o | output | 3 | Current state code |
| power_o | output | 40 | Last measured window power |

## Verification
The case that is hardest to reach from the ports is the boundary decision, where the measured power equals the threshold exactly and must not trigger. Reaching it needs a threshold that matches the exact sum of squares. The bench computes that sum itself from a deterministic ramp of samples with gaps, writes it as the threshold, checks that the block goes back to sleep, and then reruns with the threshold one lower. Frozen configuration is shown in a similar way: writes of a zero threshold and a short sleep are made while the block is asleep, and the bench then shows that neither the next decision nor the next sleep length changed.

// File: rtl/rx_watch_pkg.sv
package rx_watch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_MEAS   = 3'd3,
    ST_EVAL   = 3'd4,
    ST_FOUND  = 3'd5
  } mon_state_t;

  localparam logic [2:0] A_SLEEP  = 3'd0;
  localparam logic [2:0] A_SETTLE = 3'd1;
  localparam logic [2:0] A_WIN    = 3'd2;
  localparam logic [2:0] A_THR    = 3'd3;
  localparam logic [2:0] A_HOP    = 3'd4;
  localparam logic [2:0] A_TBL    = 3'd5;

  localparam int HOP_LEN_LSB = 4;
  localparam int SLOT_LSB    = 16;

endpackage

// File: rtl/rx_watch_cfg.sv
module rx_watch_cfg
  import rx_watch_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int LO_W   = 6,
  parameter int HOP_N  = 8,
  parameter int PTR_W  = $clog2(HOP_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [CNT_W-1:0]  sleep_eff,
  output logic [CNT_W-1:0]  settle_eff,
  output logic [CNT_W-1:0]  win_eff,
  output logic [DATA_W-1:0] thr,
  output logic              hop_en,
  output logic [PTR_W-1:0]  hop_last,
  output logic [LO_W-1:0]   lo_val
);

  logic [CNT_W-1:0]  sleep_q, settle_q, win_q;
  logic [DATA_W-1:0] thr_q;
  logic              hop_en_q;
  logic [PTR_W:0]    hop_len_q;
  logic [LO_W-1:0]   tbl_q [HOP_N];
  logic              wr_acc;
  logic [PTR_W-1:0]  wr_slot;

  assign wr_acc  = wr_ok && cfg_we;
  assign wr_slot = cfg_wdata[SLOT_LSB +: PTR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q   <= '0;
      settle_q  <= '0;
      win_q     <= '0;
      thr_q     <= '0;
      hop_en_q  <= 1'b0;
      hop_len_q <= '0;
    end else if (wr_acc) begin
      case (cfg_addr)
        A_SLEEP:  sleep_q  <= cfg_wdata[CNT_W-1:0];
        A_SETTLE: settle_q <= cfg_wdata[CNT_W-1:0];
        A_WIN:    win_q    <= cfg_wdata[CNT_W-1:0];
        A_THR:    thr_q    <= cfg_wdata;
        A_HOP: begin
          hop_en_q  <= cfg_wdata[0];
          hop_len_q <= cfg_wdata[HOP_LEN_LSB +: PTR_W+1];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < HOP_N; g++) begin : g_tbl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl_q[g] <= '0;
      end else if (wr_acc && (cfg_addr == A_TBL) && (wr_slot == PTR_W'(g))) begin
        tbl_q[g] <= cfg_wdata[LO_W-1:0];
      end
    end
  end

  always_comb begin
    if (hop_len_q == '0) begin
      hop_last = '0;
    end else if (hop_len_q > (PTR_W+1)'(HOP_N)) begin
      hop_last = PTR_W'(HOP_N - 1);
    end else begin
      hop_last = PTR_W'(hop_len_q - 1'b1);
    end
  end

  assign sleep_eff  = (sleep_q  == '0) ? CNT_W'(1) : sleep_q;
  assign settle_eff = (settle_q == '0) ? CNT_W'(1) : settle_q;
  assign win_eff    = (win_q    == '0) ? CNT_W'(1) : win_q;
  assign thr        = thr_q;
  assign hop_en     = hop_en_q;
  assign lo_val     = tbl_q[rd_ptr];

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_ok) |=> ($stable(thr_q) && $stable(sleep_q) && $stable(win_q)
                            && $stable(settle_q) && $stable(hop_len_q)));

endmodule

// File: rtl/rx_watch_pwr.sv
module rx_watch_pwr #(
  parameter int SAMP_W = 12,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     acc_en,
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_i,
  input  logic signed [SAMP_W-1:0] smp_q,
  input  logic [CNT_W-1:0]         win_eff,
  output logic                     done,
  output logic [ACC_W-1:0]         power
);

  localparam int SQ_W = 2 * SAMP_W;

  logic signed [SQ_W-1:0] sq_i, sq_q;
  logic [SQ_W:0]          mag;
  logic [ACC_W-1:0]       acc_q, acc_nxt, power_q;
  logic [CNT_W-1:0]       cnt_q;

  assign sq_i    = smp_i * smp_i;
  assign sq_q    = smp_q * smp_q;
  assign mag     = {1'b0, sq_i} + {1'b0, sq_q};
  assign acc_nxt = acc_q + ACC_W'(mag);
  assign done    = acc_en && smp_valid && (cnt_q == win_eff - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (!acc_en) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_valid) begin
      acc_q <= acc_nxt;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      power_q <= '0;
    end else if (done) begin
      power_q <= acc_nxt;
    end
  end

  assign power = power_q;

  // R4
  acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && $past(acc_en)) |-> (acc_q >= $past(acc_q)));

  // R4
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && $past(!acc_en)) |-> (acc_q == '0));

endmodule

// File: rtl/rx_watch_fsm.sv
module rx_watch_fsm
  import rx_watch_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  parameter int PTR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_en,
  input  logic              irq_clr,
  input  logic [CNT_W-1:0]  sleep_eff,
  input  logic [CNT_W-1:0]  settle_eff,
  input  logic              hop_en,
  input  logic [PTR_W-1:0]  hop_last,
  input  logic              win_done,
  input  logic [ACC_W-1:0]  power,
  input  logic [DATA_W-1:0] thr,
  output mon_state_t        state,
  output logic [PTR_W-1:0]  ptr
);

  mon_state_t       st_q, st_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic             mon_q;
  logic             above;

  assign above = power > ACC_W'(thr);

  always_comb begin
    st_nxt = st_q;
    if (!mon_en) begin
      st_nxt = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:   if (!mon_q) st_nxt = ST_SLEEP;
        ST_SLEEP:  if (cnt_q == sleep_eff - CNT_W'(1)) st_nxt = ST_SETTLE;
        ST_SETTLE: if (cnt_q == settle_eff - CNT_W'(1)) st_nxt = ST_MEAS;
        ST_MEAS:   if (win_done) st_nxt = ST_EVAL;
        ST_EVAL:   st_nxt = above ? ST_FOUND : ST_SLEEP;
        ST_FOUND:  if (irq_clr) st_nxt = ST_IDLE;
        default:   st_nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cnt_en  = (st_nxt != st_q) || (st_q == ST_SLEEP) || (st_q == ST_SETTLE);
    cnt_nxt = (st_nxt != st_q) ? '0 : cnt_q + CNT_W'(1);
  end

  always_comb begin
    ptr_nxt = ptr_q;
    if (st_q == ST_IDLE) begin
      ptr_nxt = '0;
    end else if (hop_en && (st_q == ST_EVAL) && (st_nxt == ST_SLEEP)) begin
      ptr_nxt = (ptr_q == hop_last) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      mon_q <= 1'b0;
    end else begin
      st_q  <= st_nxt;
      ptr_q <= ptr_nxt;
      mon_q <= mon_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign state = st_q;
  assign ptr   = ptr_q;

  // R2
  sleep_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SETTLE && $past(st_q) != ST_SETTLE) |->
      ($past(st_q) == ST_SLEEP && $past(cnt_q) == sleep_eff - CNT_W'(1)));

  // R5
  found_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL && mon_en && power > {{(ACC_W-DATA_W){1'b0}}, thr}) |=> (st_q == ST_FOUND));

  // R6
  resleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EVAL && mon_en && !(power > {{(ACC_W-DATA_W){1'b0}}, thr})) |=> (st_q == ST_SLEEP));

  // R9
  found_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FOUND && mon_en && !irq_clr) |=> (st_q == ST_FOUND));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> (st_q == ST_IDLE));

  // R8
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (ptr_q <= hop_last));

endmodule

// File: rtl/rx_watch_ctrl.sv
module rx_watch_ctrl
  import rx_watch_pkg::*;
#(
  parameter int SAMP_W = 12,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32,
  parameter int ACC_W  = 40,
  parameter int LO_W   = 6,
  parameter int HOP_N  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [2:0]               cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  input  logic                     mon_en,
  input  logic                     irq_clr,
  input  logic                     smp_valid,
  input  logic signed [SAMP_W-1:0] smp_i,
  input  logic signed [SAMP_W-1:0] smp_q,
  output logic                     rx_en,
  output logic                     full_rx_req,
  output logic                     irq,
  output logic [LO_W-1:0]          lo_idx,
  output logic [2:0]               state_o,
  output logic [ACC_W-1:0]         power_o
);

  localparam int PTR_W = $clog2(HOP_N);

  mon_state_t        st;
  logic [CNT_W-1:0]  sleep_eff, settle_eff, win_eff;
  logic [DATA_W-1:0] thr;
  logic              hop_en;
  logic [PTR_W-1:0]  hop_last, ptr, rd_ptr;
  logic              win_done;
  logic              wr_ok;

  assign wr_ok  = (st == ST_IDLE) && !mon_en;
  assign rd_ptr = hop_en ? ptr : '0;

  rx_watch_cfg #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .LO_W(LO_W), .HOP_N(HOP_N), .PTR_W(PTR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rd_ptr(rd_ptr),
    .sleep_eff(sleep_eff), .settle_eff(settle_eff), .win_eff(win_eff),
    .thr(thr), .hop_en(hop_en), .hop_last(hop_last), .lo_val(lo_idx)
  );

  rx_watch_pwr #(
    .SAMP_W(SAMP_W), .CNT_W(CNT_W), .ACC_W(ACC_W)
  ) u_pwr (
    .clk(clk), .rst_n(rst_n), .acc_en(st == ST_MEAS), .smp_valid(smp_valid),
    .smp_i(smp_i), .smp_q(smp_q), .win_eff(win_eff),
    .done(win_done), .power(power_o)
  );

  rx_watch_fsm #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ACC_W(ACC_W), .PTR_W(PTR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .irq_clr(irq_clr),
    .sleep_eff(sleep_eff), .settle_eff(settle_eff), .hop_en(hop_en),
    .hop_last(hop_last), .win_done(win_done), .power(power_o), .thr(thr),
    .state(st), .ptr(ptr)
  );

  always_comb begin
    rx_en       = (st == ST_SETTLE) || (st == ST_MEAS) || (st == ST_EVAL) || (st == ST_FOUND);
    irq         = (st == ST_FOUND);
    full_rx_req = (st == ST_FOUND);
  end

  assign state_o = st;

  // R2
  sleep_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLEEP) |-> !rx_en);

  // R5
  found_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (full_rx_req && $past(st) == ST_EVAL));

endmodule

// File: tb/sim_rx_watch_ctrl.sv
`timescale 1ns/1ps
module sim_rx_watch_ctrl;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_we;
  logic [2:0]         cfg_addr;
  logic [31:0]        cfg_wdata;
  logic               mon_en, irq_clr, smp_valid;
  logic signed [11:0] smp_i, smp_q;
  logic               rx_en, full_rx_req, irq;
  logic [5:0]         lo_idx;
  logic [2:0]         state_o;
  logic [39:0]        power_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rx_watch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .mon_en(mon_en), .irq_clr(irq_clr),
    .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q), .rx_en(rx_en),
    .full_rx_req(full_rx_req), .irq(irq), .lo_idx(lo_idx),
    .state_o(state_o), .power_o(power_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wait_state(input int s, input string req);
    int n = 0;
    while (int'(state_o) != s && n < 2000) begin
      step();
      n++;
    end
    chk(int'(state_o) == s, req, "reach state", state_o, s);
  endtask

  function automatic longint exp_pow(input int base, input int win);
    longint acc = 0;
    for (int k = 0; k < win; k++) begin
      longint vi = base + k;
      longint vq = -(base / 2) - k;
      acc += vi * vi + vq * vq;
    end
    return acc;
  endfunction

  task automatic arm();
    mon_en = 1'b1;
    step();
  endtask

  task automatic disarm();
    mon_en = 1'b0;
    step();
  endtask

  task automatic count_sleep(input int exp_len);
    int n = 0;
    bit rx_off = 1'b1;
    while (int'(state_o) == 1 && n < 5000) begin
      if (rx_en) rx_off = 1'b0;
      n++;
      step();
    end
    chk(n == exp_len, "R2", "sleep cycles", n, exp_len);
    chk(rx_off, "R2", "rx_en low in sleep", rx_off, 1);
  endtask

  // R3 and R4: runs the settle phase with junk samples, then a gapped ramp.
  task automatic detect(input int exp_settle, input int base, input int win);
    int n = 0;
    bit rx_on = 1'b1;
    longint e;
    while (int'(state_o) == 2 && n < 5000) begin
      if (!rx_en) rx_on = 1'b0;
      smp_valid = 1'b1; smp_i = 12'sd2047; smp_q = -12'sd2047;
      n++;
      step();
    end
    chk(n == exp_settle, "R3", "settle cycles", n, exp_settle);
    chk(rx_on, "R3", "rx_en high in settle", rx_on, 1);
    chk(state_o == 3'd3, "R3", "measure after settle", state_o, 3);
    for (int k = 0; k < win; k++) begin
      if (k % 2 == 1) begin
        smp_valid = 1'b0; smp_i = 12'sd2047; smp_q = 12'sd2047;
        step();
      end
      smp_valid = 1'b1;
      smp_i = 12'(base + k);
      smp_q = 12'(-(base / 2) - k);
      step();
    end
    smp_valid = 1'b0;
    e = exp_pow(base, win);
    chk(state_o == 3'd4, "R4", "evaluate after window", state_o, 4);
    chk(power_o == 40'(e), "R4", "window power", longint'(power_o), e);
  endtask

  task automatic t_reset();
    chk(state_o == 3'd0, "R1", "reset state", state_o, 0);
    chk(!rx_en && !irq && !full_rx_req, "R1", "reset outputs",
        {rx_en, irq, full_rx_req}, 0);
    chk(power_o == '0, "R1", "reset power", longint'(power_o), 0);
  endtask

  task automatic t_loop();
    wr(3'd0, 5); wr(3'd1, 3); wr(3'd2, 4); wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 0); wr(3'd5, 32'd7);
    arm();
    chk(state_o == 3'd1, "R2", "sleep after arm", state_o, 1);
    count_sleep(5);
    chk(lo_idx == 6'd7, "R8", "fixed lo entry 0", lo_idx, 7);
    detect(3, 20, 4);
    step();
    chk(state_o == 3'd1, "R6", "back to sleep", state_o, 1);
    chk(!irq, "R6", "no irq", irq, 0);
    count_sleep(5);
    chk(lo_idx == 6'd7, "R8", "fixed lo second detect", lo_idx, 7);
    detect(3, 300, 4);
    disarm();
    chk(state_o == 3'd0, "R10", "idle after disarm", state_o, 0);
  endtask

  task automatic t_threshold();
    longint e = exp_pow(100, 4);
    wr(3'd3, 32'(e));
    arm();
    wait_state(2, "R6");
    detect(3, 100, 4);
    step();
    chk(state_o == 3'd1, "R6", "equal power stays in loop", state_o, 1);
    disarm();
    wr(3'd3, 32'(e - 1));
    arm();
    wait_state(2, "R5");
    detect(3, 100, 4);
    step();
    chk(state_o == 3'd5, "R5", "found state", state_o, 5);
    chk(irq && full_rx_req && rx_en, "R5", "found outputs",
        {irq, full_rx_req, rx_en}, 7);
    repeat (20) step();
    chk(state_o == 3'd5 && irq, "R9", "found held", state_o, 5);
    irq_clr = 1'b1;
    step();
    irq_clr = 1'b0;
    chk(state_o == 3'd0, "R9", "idle after clear", state_o, 0);
    chk(!irq && !full_rx_req, "R9", "irq dropped", irq, 0);
    repeat (5) step();
    chk(state_o == 3'd0, "R9", "no restart without new edge", state_o, 0);
    disarm();
  endtask

  task automatic t_frozen();
    arm();
    wr(3'd3, 0);
    wr(3'd0, 1);
    wait_state(2, "R7");
    detect(3, 1, 4);
    step();
    chk(state_o == 3'd1, "R7", "threshold write ignored", state_o, 1);
    count_sleep(5);
    disarm();
  endtask

  task automatic t_hop();
    int exp_lo[4] = '{10, 20, 30, 10};
    wr(3'd5, 32'h0000_000A); wr(3'd5, 32'h0001_0014);
    wr(3'd5, 32'h0002_001E); wr(3'd5, 32'h0003_0028);
    wr(3'd4, 32'h31); wr(3'd0, 2); wr(3'd3, 32'hFFFF_FFFF);
    arm();
    for (int r = 0; r < 4; r++) begin
      wait_state(2, "R8");
      chk(int'(lo_idx) == exp_lo[r], "R8", "hop entry", lo_idx, exp_lo[r]);
      detect(3, 10 + r, 4);
      step();
    end
    disarm();
  endtask

  task automatic t_bounds();
    wr(3'd4, 0); wr(3'd0, 0); wr(3'd2, 0);
    arm();
    count_sleep(1);
    detect(3, 50, 1);
    step();
    wait_state(3, "R10");
    mon_en = 1'b0;
    step();
    chk(state_o == 3'd0, "R10", "abort from measure", state_o, 0);
    chk(!rx_en, "R10", "rx off after abort", rx_en, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    mon_en = 1'b0; irq_clr = 1'b0; smp_valid = 1'b0; smp_i = '0; smp_q = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_loop();
    t_threshold();
    t_frozen();
    t_hop();
    t_bounds();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule